// File: doc/BRIEF.md
# Counting Array Updater for a Split Membership Filter

This block is the slow half of a membership filter that has been split in two. It sits next to a cache and takes one event at a time. An event is either an allocation, which reports a line being brought in, or an eviction, which reports a line being removed. Each event carries the line address. The block folds that address into a table index with an XOR hash. The remote single-bit presence vector uses the same hash. The block then reads the small counter stored at that index, adjusts it and writes it back.

A message to the presence vector is produced only when a counter moves between zero and non-zero. The message is one bit: set when the count leaves zero, clear when it returns to zero. Every other change stays local. The allocation event should be issued when the cache miss occurs, not when the fill arrives, so that the remote bit is already set before the line is present.

A counter that would overflow is frozen for good. It then stays non-zero, so its remote bit stays set. Eviction reports that would take an active counter below zero are dropped and flagged on an error output.

Top module: `cbf_counter_updater`

## Requirements
- R1: The table index is the XOR of the address split into IDX_W-bit chunks. The first chunk is address bits [IDX_W-1:0], and the highest chunk is padded with zeros above the address width.
- R2: `ev_ready` is high whenever no event is in progress. It goes low for exactly one cycle after an event is accepted (`ev_valid` and `ev_ready` high at a clock edge). The results of that event appear on the outputs, one cycle wide, in the cycle after the ready-low cycle.
- R3: An allocation whose counter reads zero raises `upd_valid` with `upd_set`=1 and `upd_idx` equal to the hashed index.
- R4: An eviction whose counter reads one raises `upd_valid` with `upd_set`=0 and `upd_idx` equal to the hashed index.
- R5: An event that does not move its counter across zero leaves `upd_valid` low, `upd_set` low and `upd_idx` at zero.
- R6: An allocation whose counter already holds the largest value (2^CNT_W-1) freezes that entry. No update message and no error are produced.
- R7: A frozen entry ignores both allocations and evictions. It raises neither `upd_valid` nor `err_underflow`, and no number of evictions ever produces a clear message for it.
- R8: An eviction whose counter reads zero, on an entry that is not frozen, pulses `err_underflow` and sends no update. The counter stays at zero, so the next allocation to that index produces a set message.
- R9: After reset every counter is zero, no entry is frozen, `ev_ready` is high and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_valid | input | 1 | An event is offered |
| ev_ready | output | 1 | The block can take an event this cycle |
| ev_alloc | input | 1 | 1 = allocation (count up), 0 = eviction (count down) |
| ev_addr | input | ADDR_W | Line address of the event |
| upd_valid | output | 1 | One-cycle message to the presence vector |
| upd_set | output | 1 | Bit value to write: 1 = set, 0 = clear |
| upd_idx | output | IDX_W | Presence-vector index; zero when no message is sent |
| err_underflow | output | 1 | One-cycle pulse: an eviction found an active counter at zero |

## Verification
The bench builds the block with a 12-bit address, a 4-bit index and 2-bit counters. This gives three hash chunks whose XOR is easy to work out by hand. Distinct addresses such as 0x123 and 0x321 land on the same entry, which shows counters shared between lines. With 2-bit counters, saturation and freezing are reached after only four allocations. The default values (32-bit address, 10-bit index, 3-bit counters) keep the same logic but lie too far apart for short directed runs.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RMW  = 1'b1
  } rmw_state_e;

endpackage

// File: rtl/cbf_fold_hash.sv
module cbf_fold_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] acc [NCHUNK];

  assign padded = PAD_W'(addr_i);
  assign acc[0] = padded[IDX_W-1:0];

  for (genvar g = 1; g < NCHUNK; g++) begin : g_fold
    assign acc[g] = acc[g-1] ^ padded[g*IDX_W +: IDX_W];
  end

  assign idx_o = acc[NCHUNK-1];

endmodule

// File: rtl/cbf_count_store.sv
module cbf_count_store #(
  parameter int IDX_W = 10,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_dis,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_dis
);

  localparam int DEPTH = 1 << IDX_W;

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic             dis_q [DEPTH];

  assign rd_cnt = cnt_q[rd_idx];
  assign rd_dis = dis_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cnt_q[i] <= '0;
        dis_q[i] <= 1'b0;
      end
    end else if (wr_en) begin
      cnt_q[wr_idx] <= wr_cnt;
      dis_q[wr_idx] <= wr_dis;
    end
  end

  // R7
  frozen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == rd_idx) && rd_dis) |-> wr_dis);

endmodule

// File: rtl/cbf_boundary.sv
module cbf_boundary #(
  parameter int CNT_W = 3
) (
  input  logic             inc_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dis_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dis_o,
  output logic             wr_o,
  output logic             cross_o,
  output logic             set_o,
  output logic             under_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_comb begin
    cnt_o   = cnt_i;
    dis_o   = dis_i;
    wr_o    = 1'b0;
    cross_o = 1'b0;
    set_o   = 1'b0;
    under_o = 1'b0;
    if (!dis_i) begin
      if (inc_i) begin
        wr_o = 1'b1;
        if (cnt_i == CNT_MAX) begin
          dis_o = 1'b1;
        end else begin
          cnt_o   = cnt_i + CNT_ONE;
          cross_o = (cnt_i == '0);
          set_o   = (cnt_i == '0);
        end
      end else if (cnt_i == '0) begin
        under_o = 1'b1;
      end else begin
        wr_o    = 1'b1;
        cnt_o   = cnt_i - CNT_ONE;
        cross_o = (cnt_i == CNT_ONE);
      end
    end
  end

endmodule

// File: rtl/cbf_counter_updater.sv
module cbf_counter_updater #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_alloc,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              upd_valid,
  output logic              upd_set,
  output logic [IDX_W-1:0]  upd_idx,
  output logic              err_underflow
);

  import cbf_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  rmw_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, hash_idx;
  logic             inc_q, inc_d;
  logic             accept;

  logic [CNT_W-1:0] rd_cnt, new_cnt;
  logic             rd_dis, new_dis, bd_wr, bd_cross, bd_set, bd_under;
  logic             st_wr;

  logic             upd_valid_d, upd_set_d, err_d;
  logic [IDX_W-1:0] upd_idx_d;

  cbf_fold_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr_i(ev_addr),
    .idx_o (hash_idx)
  );

  cbf_count_store #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
    .clk   (clk),
    .rst_n (rst_s_n),
    .rd_idx(idx_q),
    .rd_cnt(rd_cnt),
    .rd_dis(rd_dis),
    .wr_en (st_wr),
    .wr_idx(idx_q),
    .wr_cnt(new_cnt),
    .wr_dis(new_dis)
  );

  cbf_boundary #(.CNT_W(CNT_W)) u_bound (
    .inc_i  (inc_q),
    .cnt_i  (rd_cnt),
    .dis_i  (rd_dis),
    .cnt_o  (new_cnt),
    .dis_o  (new_dis),
    .wr_o   (bd_wr),
    .cross_o(bd_cross),
    .set_o  (bd_set),
    .under_o(bd_under)
  );

  assign ev_ready = (state_q == ST_IDLE);
  assign accept   = ev_valid && ev_ready;
  assign st_wr    = (state_q == ST_RMW) && bd_wr;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    inc_d       = inc_q;
    upd_valid_d = 1'b0;
    upd_set_d   = 1'b0;
    upd_idx_d   = '0;
    err_d       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RMW;
          idx_d   = hash_idx;
          inc_d   = ev_alloc;
        end
      end
      ST_RMW: begin
        state_d     = ST_IDLE;
        upd_valid_d = bd_cross;
        upd_set_d   = bd_cross && bd_set;
        upd_idx_d   = bd_cross ? idx_q : '0;
        err_d       = bd_under;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q       <= ST_IDLE;
      idx_q         <= '0;
      inc_q         <= 1'b0;
      upd_valid     <= 1'b0;
      upd_set       <= 1'b0;
      upd_idx       <= '0;
      err_underflow <= 1'b0;
    end else begin
      state_q       <= state_d;
      idx_q         <= idx_d;
      inc_q         <= inc_d;
      upd_valid     <= upd_valid_d;
      upd_set       <= upd_set_d;
      upd_idx       <= upd_idx_d;
      err_underflow <= err_d;
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_valid && ev_ready) |=> !ev_ready);

  // R2
  result_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (upd_valid || err_underflow) |-> $past(!ev_ready));

  // R8
  err_no_update_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(upd_valid && err_underflow));

  // R5
  idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !upd_valid |-> (upd_idx == '0 && !upd_set));

endmodule

// File: tb/sim_cbf_counter_updater.sv
module sim_cbf_counter_updater;

  localparam int AW = 12;
  localparam int IW = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic          ev_alloc = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic          ev_ready, upd_valid, upd_set, err_underflow;
  logic [IW-1:0] upd_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cbf_counter_updater #(.ADDR_W(AW), .IDX_W(IW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_alloc(ev_alloc), .ev_addr(ev_addr),
    .upd_valid(upd_valid), .upd_set(upd_set), .upd_idx(upd_idx),
    .err_underflow(err_underflow)
  );

  function automatic logic [IW-1:0] fold(input logic [AW-1:0] a);
    return a[3:0] ^ a[7:4] ^ a[11:8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends one event and checks the outputs. Pass exp_v=1 for an update,
  // exp_e=1 for an underflow error.
  task automatic send(input string req, input logic alloc, input logic [AW-1:0] addr,
                      input logic exp_v, input logic exp_s, input logic exp_e);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_alloc = alloc; ev_addr = addr;
    @(posedge clk); #1;
    ev_valid = 1'b0;
    @(negedge clk);
    check({req, "/R2 busy"}, {31'd0, ev_ready}, 32'd0);
    @(negedge clk);
    check({req, "/R2 ready"}, {31'd0, ev_ready}, 32'd1);
    check({req, " valid"}, {31'd0, upd_valid}, {31'd0, exp_v});
    check({req, " set"}, {31'd0, upd_set}, {31'd0, exp_v & exp_s});
    check({req, "/R1 idx"}, {28'd0, upd_idx}, exp_v ? {28'd0, fold(addr)} : 32'd0);
    check({req, " err"}, {31'd0, err_underflow}, {31'd0, exp_e});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 ready", {31'd0, ev_ready}, 32'd1);
    check("R9 upd_valid", {31'd0, upd_valid}, 32'd0);
    check("R9 err", {31'd0, err_underflow}, 32'd0);
  endtask

  task automatic t_share_and_clear;
    send("R3 first alloc", 1'b1, 12'h123, 1'b1, 1'b1, 1'b0);
    send("R5 shared alloc", 1'b1, 12'h321, 1'b0, 1'b0, 1'b0);
    send("R5 evict 2->1", 1'b0, 12'h123, 1'b0, 1'b0, 1'b0);
    send("R4 evict 1->0", 1'b0, 12'h321, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_underflow;
    send("R8 evict at zero", 1'b0, 12'h123, 1'b0, 1'b0, 1'b1);
    send("R8 alloc after", 1'b1, 12'h123, 1'b1, 1'b1, 1'b0);
    send("R4 clean up", 1'b0, 12'h123, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hash_spread;
    send("R1 hash A5C", 1'b1, 12'hA5C, 1'b1, 1'b1, 1'b0);
    send("R1 hash F0E", 1'b1, 12'hF0E, 1'b1, 1'b1, 1'b0);
    send("R4 hash A5C clear", 1'b0, 12'hA5C, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_saturate;
    send("R3 sat step1", 1'b1, 12'h005, 1'b1, 1'b1, 1'b0);
    send("R5 sat step2", 1'b1, 12'h005, 1'b0, 1'b0, 1'b0);
    send("R5 sat step3", 1'b1, 12'h005, 1'b0, 1'b0, 1'b0);
    send("R6 freeze", 1'b1, 12'h005, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++)
      send("R7 frozen evict", 1'b0, 12'h005, 1'b0, 1'b0, 1'b0);
    send("R7 frozen alloc", 1'b1, 12'h005, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_share_and_clear();
    t_underflow();
    t_hash_spread();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule